// File: doc/BRIEF.md
# Dual-Buffer Receive Frame Store with Destination Filter

This block is the receive half of a small Ethernet MAC. Frames arrive as a byte stream with a start marker on the first byte and an end marker on the last. The block checks each frame's destination address against a station address and writes the frame into one of two receive buffers. Group-addressed frames always pass. Unicast frames pass only when all six destination bytes match. The host reads both buffers over a 32-bit word bus.

Bytes are written into the target buffer as they arrive. The decision to keep or discard a frame is made on its last byte. A stored frame sets the full flag of its buffer and can raise a one-cycle interrupt pulse. When alternation is enabled, the next frame goes to the other buffer. The host frees a buffer by writing its control word with the full flag at zero. A frame that finds its target buffer full is dropped and counted in a saturating lost-frame counter.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset both full flags read 0, the lost-frame counter reads 0, `irq` is low, and the first stored frame goes to buffer 0.
- R2: A frame is accepted when bit 0 of its first byte is 1 (group address). Otherwise its bytes 0..5 must equal `station_addr[47:40]` .. `station_addr[7:0]` in that order. A frame that fails this check is discarded with no change to the full flags, the lost counter or `irq`.
- R3: Byte n of a frame is stored in bits 8*(n%4)+7 .. 8*(n%4) of the word at byte offset 4*(n/4) from the buffer base. Buffer 0 starts at 0x1000 and buffer 1 at 0x1800. Unused lanes of the last word read 0.
- R4: On the clock edge that takes the last byte of an accepted frame, the full flag of the target buffer is set. The full flag is bit 0 of the control word: 0x17FC for buffer 0 and 0x1FFC for buffer 1.
- R5: If the target buffer's full flag is 1 when a frame starts, an accepted frame is not written, neither buffer changes, and the lost counter (read at 0x0FFC) goes up by one.
- R6: The lost counter stops at 2^LOST_W-1.
- R7: A frame longer than BUF_BYTES-4 bytes (2044 by default) is rejected and its full flag stays 0. A frame of exactly BUF_BYTES-4 bytes is stored.
- R8: `irq` is high for exactly the one cycle after a frame is stored, and only when bit 3 of control word 0 and bit 31 of the enable word at 0x0FF8 are both 1. Bit 3 of control word 1 has no effect on `irq`.
- R9: With `alt_en`=1 the target toggles after each stored frame. With `alt_en`=0 every frame targets buffer 0. Dropped and rejected frames never move the target.
- R10: A host write to a control word clears the full flag when bit 0 is 0. Writing 1 to bit 0 leaves the flag as it was. Bit 3 always takes the written value.
- R11: `bus_rdata` holds the addressed word in the cycle after `bus_re` is sampled. A control word reads as bit 3 = interrupt enable and bit 0 = full, with all other bits 0.
- R12: Bytes that arrive while no frame is open (no start marker seen since the last end marker) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte present on `rx_data` |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Own address; bits 47:40 are the first byte on the wire |
| alt_en | input | 1 | Alternate between the two buffers |
| bus_addr | input | ADDR_W | Byte address of the host access, word aligned |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, one cycle after `bus_re` |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every result is due a fixed number of edges after its stimulus.
- The full flags, the lost counter, the target buffer and `irq` all change on the edge that takes the end-marked byte.
- `irq` must fall again one edge later.
- Read data appears on the edge that samples `bus_re`.

The bench drives inputs and samples outputs on the falling edge. It reads `irq` at the falling edge right after the last byte, and reads it again one falling edge later to confirm the pulse is a single cycle. Each read task returns `bus_rdata` at the falling edge that follows the strobe.

// File: rtl/rx_pingpong_pkg.sv
package rx_pingpong_pkg;
   // bit positions inside the host-visible words
   localparam int unsigned FULL_BIT  = 0;
   localparam int unsigned IEN_BIT   = 3;
   localparam int unsigned GEN_BIT   = 31;
   localparam int unsigned MAC_BYTES = 6;

   typedef enum logic [1:0] {
      RD_REG  = 2'd0,
      RD_DATA = 2'd1
   } rd_kind_e;
endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter
   import rx_pingpong_pkg::*;
#(
   parameter int unsigned IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             first,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       data,
   input  logic [47:0]      station,
   output logic             pass
);
   logic [MAC_BYTES-1:0] byte_hit;
   logic grp_q, ok_q, grp_c, ok_c, pos_hit;

   for (genvar k = 0; k < MAC_BYTES; k++) begin : g_hit
      assign byte_hit[k] = (data == station[8*(MAC_BYTES-1-k) +: 8]);
   end

   always_comb begin
      pos_hit = 1'b1;
      for (int k = 0; k < MAC_BYTES; k++)
         if (idx == IDX_W'(k)) pos_hit = byte_hit[k];
      grp_c = first ? data[0] : grp_q;
      ok_c  = (first ? 1'b1 : ok_q) & pos_hit;
      pass  = grp_c | (ok_c & (idx >= IDX_W'(MAC_BYTES-1)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q <= 1'b0;
         ok_q  <= 1'b0;
      end else if (beat) begin
         grp_q <= grp_c;
         ok_q  <= ok_c;
      end
   end
endmodule

// File: rtl/rxpp_seq.sv
module rxpp_seq #(
   parameter int unsigned WIDX_W = 9,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned CAP    = 2044
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [7:0]        rx_data,
   input  logic              alt_en,
   input  logic [1:0]        full_vec,
   input  logic [47:0]       station,
   output logic              mem_we,
   output logic [WIDX_W:0]   mem_waddr,
   output logic [31:0]       mem_wdata,
   output logic              commit,
   output logic              commit_buf,
   output logic              lost_inc,
   output logic              tgt
);
   logic             in_frame, full_q, sel_q, full_c, room, beat, endb, pass;
   logic [CNT_W-1:0] cnt, idx;
   logic [31:0]      word_q, wnext;
   logic [1:0]       lane;

   assign beat = rx_valid & (rx_sof | in_frame);
   assign idx  = rx_sof ? '0 : cnt;
   assign tgt  = alt_en & sel_q;
   assign full_c = rx_sof ? full_vec[tgt] : full_q;
   assign room = (idx < CNT_W'(CAP));
   assign lane = idx[1:0];
   assign endb = beat & rx_eof;

   rxpp_addr_filter #(.IDX_W(CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first(rx_sof),
      .idx(idx), .data(rx_data), .station(station), .pass(pass)
   );

   always_comb begin
      wnext = (lane == 2'd0) ? 32'd0 : word_q;
      for (int l = 0; l < 4; l++)
         if (lane == 2'(l)) wnext[8*l +: 8] = rx_data;
   end

   assign mem_we     = beat & ~full_c & room & ((lane == 2'd3) | rx_eof);
   assign mem_waddr  = {tgt, idx[WIDX_W+1:2]};
   assign mem_wdata  = wnext;
   assign commit     = endb & pass & ~full_c & room;
   assign commit_buf = tgt;
   assign lost_inc   = endb & pass & full_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         cnt      <= '0;
         word_q   <= '0;
         full_q   <= 1'b0;
         sel_q    <= 1'b0;
      end else begin
         if (beat) begin
            in_frame <= ~rx_eof;
            cnt      <= rx_eof ? '0 : (room ? idx + 1'b1 : idx);
            word_q   <= wnext;
            full_q   <= full_c;
         end
         if (commit && alt_en) sel_q <= ~sel_q;
      end
   end
endmodule

// File: rtl/rxpp_ram.sv
module rxpp_ram #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [2**AW];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf
   import rx_pingpong_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 2048,
   parameter int unsigned LOST_W    = 8,
   localparam int unsigned ADDR_W   = $clog2(4*BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [7:0]        rx_data,
   input  logic [47:0]       station_addr,
   input  logic              alt_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   localparam int unsigned BB      = $clog2(BUF_BYTES);
   localparam int unsigned WIDX_W  = BB - 2;
   localparam int unsigned CAP     = BUF_BYTES - 4;
   localparam int unsigned CNT_W   = BB + 1;
   localparam int unsigned RX_BASE = 2*BUF_BYTES;
   localparam logic [ADDR_W-1:0] GEN_A  = ADDR_W'(RX_BASE - 8);
   localparam logic [ADDR_W-1:0] LOST_A = ADDR_W'(RX_BASE - 4);

   initial begin
      assert ((BUF_BYTES >= 64) && ((BUF_BYTES & (BUF_BYTES-1)) == 0))
         else $error("BUF_BYTES must be a power of two of at least 64");
      assert ((LOST_W >= 1) && (LOST_W <= 32))
         else $error("LOST_W must lie in 1..32");
   end

   logic [1:0]        stat, ien, is_ctrl;
   logic              gen, commit, commit_buf, lost_inc, mem_we, tgt, in_rx;
   logic [LOST_W-1:0] lost;
   logic [WIDX_W:0]   mem_waddr;
   logic [31:0]       mem_wdata, mem_q, reg_q, reg_c;
   rd_kind_e          kind_q;

   rxpp_seq #(.WIDX_W(WIDX_W), .CNT_W(CNT_W), .CAP(CAP)) u_seq (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_data(rx_data), .alt_en(alt_en), .full_vec(stat),
      .station(station_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .commit(commit), .commit_buf(commit_buf),
      .lost_inc(lost_inc), .tgt(tgt)
   );

   assign in_rx = (bus_addr >= ADDR_W'(RX_BASE));

   rxpp_ram #(.AW(WIDX_W+1), .DW(32)) u_ram (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .re(bus_re & in_rx), .raddr({bus_addr[BB], bus_addr[BB-1:2]}),
      .rdata(mem_q)
   );

   // one control word per buffer: full flag and interrupt enable
   for (genvar b = 0; b < 2; b++) begin : g_ctrl
      assign is_ctrl[b] = (bus_addr == ADDR_W'(RX_BASE + (b+1)*BUF_BYTES - 4));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stat[b] <= 1'b0;
            ien[b]  <= 1'b0;
         end else begin
            if (bus_we && is_ctrl[b]) ien[b] <= bus_wdata[IEN_BIT];
            if (commit && (commit_buf == 1'(b)))
               stat[b] <= 1'b1;
            else if (bus_we && is_ctrl[b] && !bus_wdata[FULL_BIT])
               stat[b] <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_c = '0;
      if (is_ctrl[0]) begin
         reg_c[IEN_BIT] = ien[0]; reg_c[FULL_BIT] = stat[0];
      end else if (is_ctrl[1]) begin
         reg_c[IEN_BIT] = ien[1]; reg_c[FULL_BIT] = stat[1];
      end else if (bus_addr == GEN_A) begin
         reg_c[GEN_BIT] = gen;
      end else if (bus_addr == LOST_A) begin
         reg_c = 32'(lost);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen    <= 1'b0;
         lost   <= '0;
         irq    <= 1'b0;
         reg_q  <= '0;
         kind_q <= RD_REG;
      end else begin
         if (bus_we && bus_addr == GEN_A) gen <= bus_wdata[GEN_BIT];
         if (lost_inc && lost != {LOST_W{1'b1}}) lost <= lost + 1'b1;
         irq <= commit & ien[0] & gen;
         if (bus_re) begin
            reg_q  <= reg_c;
            kind_q <= (in_rx && is_ctrl == 2'b00) ? RD_DATA : RD_REG;
         end
      end
   end

   assign bus_rdata = (kind_q == RD_DATA) ? mem_q : reg_q;
endmodule

// File: rtl/rx_pingpong_buf_chk.sv
module rx_pingpong_buf_chk #(
   parameter int unsigned LOST_W = 8,
   parameter int unsigned WIDX_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              gen,
   input logic [1:0]        ien,
   input logic [1:0]        stat,
   input logic              commit,
   input logic              commit_buf,
   input logic              alt_en,
   input logic [LOST_W-1:0] lost,
   input logic              mem_we,
   input logic [WIDX_W:0]   mem_waddr
);
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(gen && ien[0])) else $error("irq without enables"); // R8
   AST_IRQ_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(commit)) else $error("irq without stored frame"); // R8
   AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !stat[mem_waddr[WIDX_W]]) else $error("write into full buffer"); // R5
   AST_FULL0_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[0]) |-> $past(commit && !commit_buf)) else $error("flag 0 set"); // R4
   AST_FULL1_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[1]) |-> $past(commit && commit_buf)) else $error("flag 1 set"); // R4
   AST_LOST_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (lost == {LOST_W{1'b1}}) |=> (lost == {LOST_W{1'b1}})) else $error("wrap"); // R6
   AST_LOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (lost != $past(lost)) |-> (lost == $past(lost) + 1'b1)) else $error("step"); // R5
   AST_FIXED_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !alt_en) |-> !commit_buf) else $error("buffer 1 used"); // R9
endmodule

bind rx_pingpong_buf rx_pingpong_buf_chk #(.LOST_W(LOST_W), .WIDX_W(WIDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .gen(gen), .ien(ien), .stat(stat),
   .commit(commit), .commit_buf(commit_buf), .alt_en(alt_en), .lost(lost),
   .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/sim_rx_pingpong_buf.sv
module sim_rx_pingpong_buf;
   localparam logic [12:0] BUF0 = 13'h1000, BUF1 = 13'h1800;
   localparam logic [12:0] CTL0 = 13'h17FC, CTL1 = 13'h1FFC;
   localparam logic [12:0] GENA = 13'h0FF8, LOSTA = 13'h0FFC;
   localparam logic [47:0] STA  = 48'h02_11_22_33_44_55;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, alt_en = 0;
   logic [7:0]  rx_data = '0;
   logic [12:0] bus_addr = '0;
   logic        bus_we = 0, bus_re = 0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq, irq_seen, done = 0;
   logic [7:0]  fr [0:2047];
   int          n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   rx_pingpong_buf u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_data(rx_data), .station_addr(STA), .alt_en(alt_en),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [31:0] d);
      @(negedge clk); bus_re = 1; bus_addr = a;
      @(negedge clk); bus_re = 0; d = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [12:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic build(input logic [47:0] da, input int len, input logic [7:0] seed);
      for (int i = 0; i < len; i++)
         fr[i] = (i < 6) ? da[8*(5-i) +: 8] : 8'(seed + i);
   endtask

   function automatic logic [31:0] wexp(input int w, input int len);
      logic [31:0] r = '0;
      for (int l = 0; l < 4; l++)
         if (4*w + l < len) r[8*l +: 8] = fr[4*w + l];
      return r;
   endfunction

   task automatic send(input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len-1); rx_data = fr[i];
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0;
      irq_seen = irq;
   endtask

   task automatic t_reset;
      chk("R1 irq low after reset", 32'(irq), 0);
      rd_chk("R1 ctrl0 after reset", CTL0, 0);
      rd_chk("R1 ctrl1 after reset", CTL1, 0);
      rd_chk("R1 lost after reset", LOSTA, 0);
   endtask

   task automatic t_unicast_hit;
      wr(GENA, 32'h8000_0000);
      wr(CTL0, 32'h8);
      rd_chk("R11 enable word", GENA, 32'h8000_0000);
      build(STA, 10, 8'h30);
      send(10);
      chk("R8 irq pulse after store", 32'(irq_seen), 1);
      @(negedge clk);
      chk("R8 irq one cycle", 32'(irq), 0);
      rd_chk("R4 R11 ctrl0 full", CTL0, 32'h9);
      rd_chk("R1 first frame in buffer 0 ctrl1", CTL1, 0);
      for (int w = 0; w < 3; w++) begin
         logic [31:0] v;
         rd(BUF0 + 13'(4*w), v);
         chk("R3 stored word", v, wexp(w, 10));
      end
      wr(CTL0, 32'h8);
      rd_chk("R10 release clears full", CTL0, 32'h8);
   endtask

   task automatic t_unicast_miss;
      build(STA ^ 48'h1, 8, 8'h50);
      send(8);
      chk("R2 miss no irq", 32'(irq_seen), 0);
      rd_chk("R2 miss ctrl0 clear", CTL0, 32'h8);
      rd_chk("R2 miss lost unchanged", LOSTA, 0);
   endtask

   task automatic t_group;
      build(48'h03_9A_BC_DE_F0_12, 6, 8'h00);
      send(6);
      rd_chk("R2 group accepted", CTL0, 32'h9);
      rd_chk("R3 group word0", BUF0, wexp(0, 6));
      rd_chk("R3 group word1 zero lanes", BUF0 + 13'd4, wexp(1, 6));
      wr(CTL0, 32'h8);
   endtask

   task automatic t_set_ignored;
      wr(CTL0, 32'h1);
      rd_chk("R10 writing 1 does not set full", CTL0, 32'h0);
      wr(CTL0, 32'h8);
      rd_chk("R10 ien written", CTL0, 32'h8);
   endtask

   task automatic t_stray;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = 0; rx_eof = (i == 2); rx_data = 8'hAA;
      end
      @(negedge clk); rx_valid = 0; rx_eof = 0;
      rd_chk("R12 stray bytes no store", CTL0, 32'h8);
      rd_chk("R12 stray bytes data unchanged", BUF0, wexp(0, 6));
   endtask

   task automatic t_len;
      build(48'h01_00_00_00_00_00, 2045, 8'h00);
      send(2045);
      rd_chk("R7 overlong rejected", CTL0, 32'h8);
      rd_chk("R7 overlong not lost", LOSTA, 0);
      send(2044);
      rd_chk("R7 exact capacity stored", CTL0, 32'h9);
      rd_chk("R7 R3 last word", BUF0 + 13'd2040, wexp(510, 2044));
      wr(CTL0, 32'h8);
   endtask

   task automatic t_pingpong(output logic [31:0] wa, output logic [31:0] wb);
      alt_en = 1;
      build(48'h01_00_00_00_00_00, 8, 8'h40);
      wa = wexp(1, 8);
      send(8);
      build(48'h01_00_00_00_00_00, 8, 8'h80);
      wb = wexp(1, 8);
      send(8);
      rd_chk("R9 first to buffer 0", CTL0, 32'h9);
      rd_chk("R9 second to buffer 1", CTL1, 32'h1);
      rd_chk("R9 R3 buffer 1 data", BUF1 + 13'd4, wb);
      rd_chk("R9 buffer 0 data kept", BUF0 + 13'd4, wa);
   endtask

   task automatic t_full_drop(input logic [31:0] wa, input logic [31:0] wb);
      build(48'h01_00_00_00_00_00, 8, 8'hC8);
      send(8);
      chk("R5 drop no irq", 32'(irq_seen), 0);
      rd_chk("R5 lost counted", LOSTA, 1);
      rd_chk("R5 buffer 0 unchanged", BUF0 + 13'd4, wa);
      rd_chk("R5 buffer 1 unchanged", BUF1 + 13'd4, wb);
   endtask

   task automatic t_lost_sat;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = 1; rx_eof = 1; rx_data = 8'h01;
      end
      @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
      rd_chk("R6 lost saturates", LOSTA, 32'd255);
   endtask

   task automatic t_release_order(input logic [31:0] wb);
      logic [31:0] wd, we_;
      wr(CTL0, 32'h0);
      wr(CTL1, 32'h9);
      rd_chk("R10 write 1 keeps full", CTL1, 32'h9);
      build(48'h01_00_00_00_00_00, 8, 8'h10);
      wd = wexp(1, 8);
      send(8);
      chk("R8 no irq with ien0 clear", 32'(irq_seen), 0);
      rd_chk("R9 target back to buffer 0", CTL0, 32'h1);
      rd_chk("R3 buffer 0 new data", BUF0 + 13'd4, wd);
      build(48'h01_00_00_00_00_00, 8, 8'h20);
      we_ = wexp(1, 8);
      send(8);
      rd_chk("R5 buffer 1 full keeps data", BUF1 + 13'd4, wb);
      wr(CTL1, 32'h8);
      send(8);
      chk("R8 ien1 has no effect", 32'(irq_seen), 0);
      rd_chk("R9 target buffer 1 after drop", CTL1, 32'h9);
      rd_chk("R9 buffer 1 data", BUF1 + 13'd4, we_);
   endtask

   task automatic t_fixed;
      wr(CTL0, 32'h0);
      wr(CTL1, 32'h0);
      build(48'h01_00_00_00_00_00, 8, 8'h60);
      send(8);
      wr(CTL0, 32'h0);
      alt_en = 0;
      send(8);
      rd_chk("R9 fixed mode uses buffer 0", CTL0, 32'h1);
      rd_chk("R9 fixed mode buffer 1 idle", CTL1, 32'h0);
      send(8);
      rd_chk("R9 fixed mode no spill to buffer 1", CTL1, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] wa, wb;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_unicast_hit();
      t_unicast_miss();
      t_group();
      t_set_ignored();
      t_stray();
      t_len();
      t_pingpong(wa, wb);
      t_full_drop(wa, wb);
      t_lost_sat();
      t_release_order(wb);
      t_fixed();
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule